// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This combinational block sits beside the execute and decode stages of a five-stage in-order integer pipeline. For each of the two ALU operands in execute it picks among three candidates: the value read from the register file, the ALU result held by the execute-to-memory pipeline register, or the final result held by the memory-to-writeback register. It outputs the 2-bit select code for each operand and the operand value after the selection.

Branches in this pipeline are resolved in decode, so the block also corrects the two operands of the decode-stage equality comparator. It drives an equal flag from the corrected values. In decode, the execute-to-memory value is taken only when the producer there is not a load, because a loaded value does not exist yet at that point. The hazard unit is expected to stall in that case.

Each producer stage supplies a 2-bit writeback control bundle. Bit 1 is the register-write enable and bit 0 is the memory-to-register (load) select. Register numbers are `REG_W` bits wide (5 by default) and data is `DATA_W` bits wide (32 by default). Register 0 is hardwired to zero when `ZERO_FIXED` is 1.

Top module: `fwd_unit`

## Requirements
- R1: Each select output uses the codes 00 for register file, 10 for the execute-to-memory stage and 01 for the writeback stage, and never 11. With select 00 the operand equals its register-file input.
- R2: An execute operand whose source register matches the execute-to-memory destination gets select 10 and the `mem_alu_res` value when bit 1 of `mem_wbctl` is set. This holds whether or not bit 0 is set.
- R3: An execute operand that has no valid execute-to-memory match but does match a writing writeback producer gets select 01 and the `wb_value` value.
- R4: When both producer stages are valid and match the same source register, the execute-to-memory stage wins.
- R5: A producer whose destination is register 0 is never forwarded from, and neither is a producer whose write-enable bit (bit 1 of its bundle) is clear.
- R6: A decode operand takes select 10 and `mem_alu_res` only when the execute-to-memory producer is valid, matches, and has its load bit (bit 0 of `mem_wbctl`) clear.
- R7: When the execute-to-memory producer is a matching load, a decode operand falls back to the writeback stage on a valid match there, and otherwise to the register file.
- R8: `id_equal` is 1 exactly when the two forwarded decode operands are equal.
- R9: The A and B operands of each stage are selected independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W | Execute-stage first source register number |
| ex_src_b | input | REG_W | Execute-stage second source register number |
| ex_rf_a | input | DATA_W | Register-file value for execute operand A |
| ex_rf_b | input | DATA_W | Register-file value for execute operand B |
| id_src_a | input | REG_W | Decode-stage first source register number |
| id_src_b | input | REG_W | Decode-stage second source register number |
| id_rf_a | input | DATA_W | Register-file value for decode operand A |
| id_rf_b | input | DATA_W | Register-file value for decode operand B |
| mem_dst | input | REG_W | Destination register held in the execute-to-memory register |
| mem_wbctl | input | 2 | Bundle from that stage: bit 1 write enable, bit 0 load |
| mem_alu_res | input | DATA_W | ALU result held in the execute-to-memory register |
| wb_dst | input | REG_W | Destination register held in the writeback register |
| wb_wbctl | input | 2 | Bundle from writeback: bit 1 write enable, bit 0 load |
| wb_value | input | DATA_W | Final value being written back |
| ex_sel_a | output | 2 | Select code for execute operand A |
| ex_sel_b | output | 2 | Select code for execute operand B |
| ex_opnd_a | output | DATA_W | Forwarded execute operand A |
| ex_opnd_b | output | DATA_W | Forwarded execute operand B |
| id_sel_a | output | 2 | Select code for decode operand A |
| id_sel_b | output | 2 | Select code for decode operand B |
| id_opnd_a | output | DATA_W | Forwarded decode operand A |
| id_opnd_b | output | DATA_W | Forwarded decode operand B |
| id_equal | output | 1 | Equality of the forwarded decode operands |

## Verification
The block holds no state, so any fault in a match or priority term shows up in the same evaluation as a wrong select code and a wrong operand value. Examples are a missing zero-register or write-enable qualifier, a swapped priority, or a missing load gate in decode. The bench sweeps every combination of source registers, destinations and control bundles over a 2-bit register space and compares all nine outputs. A wrong term therefore appears as a port mismatch on the very combination that exposes it.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   localparam int CTL_W  = 2;
   localparam int CTL_WR = 1;
   localparam int CTL_LD = 0;

   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_WB  = 2'b01,
      SEL_MEM = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
   import fwd_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter bit GATE_LOAD  = 1'b0,
   parameter bit ZERO_FIXED = 1'b1,
   parameter bit USE_WB     = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] mem_dst,
   input  logic [CTL_W-1:0] mem_ctl,
   input  logic [REG_W-1:0] wb_dst,
   input  logic [CTL_W-1:0] wb_ctl,
   output fwd_sel_e         sel
);
   logic mem_nz, wb_nz, mem_hit, wb_hit, mem_load_ok;

   generate
      if (ZERO_FIXED) begin : g_zero
         assign mem_nz = |mem_dst;
         assign wb_nz  = |wb_dst;
      end else begin : g_nozero
         assign mem_nz = 1'b1;
         assign wb_nz  = 1'b1;
      end

      if (GATE_LOAD) begin : g_gate
         assign mem_load_ok = ~mem_ctl[CTL_LD];
      end else begin : g_nogate
         assign mem_load_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      mem_hit = mem_ctl[CTL_WR] && mem_nz && (mem_dst == src) && mem_load_ok;
      wb_hit  = USE_WB && wb_ctl[CTL_WR] && wb_nz && (wb_dst == src);
      if (mem_hit)     sel = SEL_MEM;
      else if (wb_hit) sel = SEL_WB;
      else             sel = SEL_RF;
   end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
   import fwd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  fwd_sel_e          sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] mem_val,
   input  logic [DATA_W-1:0] wb_val,
   output logic [DATA_W-1:0] opnd
);
   always_comb begin
      unique case (sel)
         SEL_MEM: opnd = mem_val;
         SEL_WB:  opnd = wb_val;
         default: opnd = rf_val;
      endcase
   end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter int DATA_W     = 32,
   parameter bit ZERO_FIXED = 1'b1,
   parameter bit ID_WB_FWD  = 1'b1
) (
   input  logic [REG_W-1:0]  ex_src_a,
   input  logic [REG_W-1:0]  ex_src_b,
   input  logic [DATA_W-1:0] ex_rf_a,
   input  logic [DATA_W-1:0] ex_rf_b,
   input  logic [REG_W-1:0]  id_src_a,
   input  logic [REG_W-1:0]  id_src_b,
   input  logic [DATA_W-1:0] id_rf_a,
   input  logic [DATA_W-1:0] id_rf_b,
   input  logic [REG_W-1:0]  mem_dst,
   input  logic [1:0]        mem_wbctl,
   input  logic [DATA_W-1:0] mem_alu_res,
   input  logic [REG_W-1:0]  wb_dst,
   input  logic [1:0]        wb_wbctl,
   input  logic [DATA_W-1:0] wb_value,
   output logic [1:0]        ex_sel_a,
   output logic [1:0]        ex_sel_b,
   output logic [DATA_W-1:0] ex_opnd_a,
   output logic [DATA_W-1:0] ex_opnd_b,
   output logic [1:0]        id_sel_a,
   output logic [1:0]        id_sel_b,
   output logic [DATA_W-1:0] id_opnd_a,
   output logic [DATA_W-1:0] id_opnd_b,
   output logic              id_equal
);
   localparam int N_LANE  = 4;
   localparam int FIRST_ID = 2;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_reg
         $error("fwd_unit: REG_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("fwd_unit: DATA_W must be positive");
      end
   endgenerate

   logic [REG_W-1:0]  src_v  [N_LANE];
   logic [DATA_W-1:0] rf_v   [N_LANE];
   logic [DATA_W-1:0] opnd_v [N_LANE];
   fwd_sel_e          sel_v  [N_LANE];

   assign src_v[0] = ex_src_a;
   assign src_v[1] = ex_src_b;
   assign src_v[2] = id_src_a;
   assign src_v[3] = id_src_b;
   assign rf_v[0]  = ex_rf_a;
   assign rf_v[1]  = ex_rf_b;
   assign rf_v[2]  = id_rf_a;
   assign rf_v[3]  = id_rf_b;

   generate
      for (genvar i = 0; i < N_LANE; i++) begin : g_lane
         localparam bit IS_ID = (i >= FIRST_ID);
         fwd_select #(
            .REG_W      (REG_W),
            .GATE_LOAD  (IS_ID),
            .ZERO_FIXED (ZERO_FIXED),
            .USE_WB     (IS_ID ? ID_WB_FWD : 1'b1)
         ) u_sel (
            .src     (src_v[i]),
            .mem_dst (mem_dst),
            .mem_ctl (mem_wbctl),
            .wb_dst  (wb_dst),
            .wb_ctl  (wb_wbctl),
            .sel     (sel_v[i])
         );
         fwd_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_v[i]),
            .rf_val  (rf_v[i]),
            .mem_val (mem_alu_res),
            .wb_val  (wb_value),
            .opnd    (opnd_v[i])
         );
      end
   endgenerate

   assign ex_sel_a  = sel_v[0];
   assign ex_sel_b  = sel_v[1];
   assign id_sel_a  = sel_v[2];
   assign id_sel_b  = sel_v[3];
   assign ex_opnd_a = opnd_v[0];
   assign ex_opnd_b = opnd_v[1];
   assign id_opnd_a = opnd_v[2];
   assign id_opnd_b = opnd_v[3];
   assign id_equal  = (opnd_v[2] == opnd_v[3]);
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int REG_W      = 5,
   parameter int DATA_W     = 32,
   parameter bit ZERO_FIXED = 1'b1
) (
   input logic [REG_W-1:0]  ex_src_a,
   input logic [DATA_W-1:0] ex_rf_a,
   input logic [REG_W-1:0]  mem_dst,
   input logic [1:0]        mem_wbctl,
   input logic [DATA_W-1:0] mem_alu_res,
   input logic [DATA_W-1:0] wb_value,
   input logic [1:0]        ex_sel_a,
   input logic [1:0]        ex_sel_b,
   input logic [DATA_W-1:0] ex_opnd_a,
   input logic [1:0]        id_sel_a,
   input logic [1:0]        id_sel_b,
   input logic [DATA_W-1:0] id_opnd_a,
   input logic [DATA_W-1:0] id_opnd_b,
   input logic              id_equal
);
   always_comb begin
      a_r1_no_code_11: assert (ex_sel_a != 2'b11 && ex_sel_b != 2'b11 &&
                               id_sel_a != 2'b11 && id_sel_b != 2'b11);
      a_r1_rf_value: assert (ex_sel_a != 2'b00 || ex_opnd_a == ex_rf_a);
      a_r2_mem_value: assert (ex_sel_a != 2'b10 || ex_opnd_a == mem_alu_res);
      a_r3_wb_value: assert (ex_sel_a != 2'b01 || ex_opnd_a == wb_value);
      a_r4_mem_first: assert (!(mem_wbctl[1] && mem_dst == ex_src_a &&
                                (!ZERO_FIXED || mem_dst != '0)) || ex_sel_a == 2'b10);
      a_r5_valid_producer: assert (ex_sel_a != 2'b10 ||
                                   (mem_wbctl[1] && (!ZERO_FIXED || mem_dst != '0)));
      a_r6_no_load_in_id: assert ((id_sel_a != 2'b10 && id_sel_b != 2'b10) || !mem_wbctl[0]);
      a_r8_equal_flag: assert (id_equal == (id_opnd_a == id_opnd_b));
   end
endmodule

bind fwd_unit fwd_unit_chk #(
   .REG_W      (REG_W),
   .DATA_W     (DATA_W),
   .ZERO_FIXED (ZERO_FIXED)
) u_chk (
   .ex_src_a    (ex_src_a),
   .ex_rf_a     (ex_rf_a),
   .mem_dst     (mem_dst),
   .mem_wbctl   (mem_wbctl),
   .mem_alu_res (mem_alu_res),
   .wb_value    (wb_value),
   .ex_sel_a    (ex_sel_a),
   .ex_sel_b    (ex_sel_b),
   .ex_opnd_a   (ex_opnd_a),
   .id_sel_a    (id_sel_a),
   .id_sel_b    (id_sel_b),
   .id_opnd_a   (id_opnd_a),
   .id_opnd_b   (id_opnd_b),
   .id_equal    (id_equal)
);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 2;
   localparam int DW = 8;
   localparam int WATCHDOG = 20000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [RW-1:0] ex_src_a, ex_src_b, id_src_a, id_src_b, mem_dst, wb_dst;
   logic [DW-1:0] ex_rf_a, ex_rf_b, id_rf_a, id_rf_b, mem_alu_res, wb_value;
   logic [1:0]    mem_wbctl, wb_wbctl;
   logic [1:0]    ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;
   logic [DW-1:0] ex_opnd_a, ex_opnd_b, id_opnd_a, id_opnd_b;
   logic          id_equal;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   fwd_unit #(.REG_W(RW), .DATA_W(DW), .ZERO_FIXED(1'b1), .ID_WB_FWD(1'b1)) u0 (.*);

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_sel(input logic [RW-1:0] s, input bit id_lane);
      bit mv, wv;
      mv = mem_wbctl[1] && mem_dst != 0 && mem_dst == s && !(id_lane && mem_wbctl[0]);
      wv = wb_wbctl[1] && wb_dst != 0 && wb_dst == s;
      if (mv) return 2;
      if (wv) return 1;
      return 0;
   endfunction

   function automatic int exp_val(input int sel, input logic [DW-1:0] rf);
      if (sel == 2) return int'(mem_alu_res);
      if (sel == 1) return int'(wb_value);
      return int'(rf);
   endfunction

   function automatic string tag_ex(input logic [RW-1:0] s, input int sel);
      bit wmatch = wb_wbctl[1] && wb_dst != 0 && wb_dst == s;
      if (sel == 2 && wmatch) return "R4";
      if (sel == 2) return "R2";
      if (sel == 1) return "R3";
      if (mem_dst == s || wb_dst == s) return "R5";
      return "R1";
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles >= WATCHDOG && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int e;
      string t;
      ex_rf_a = 8'h11; ex_rf_b = 8'h22; id_rf_a = 8'h33; id_rf_b = 8'h44;
      mem_alu_res = 8'h55; wb_value = 8'h66;
      ex_src_a = '0; ex_src_b = '0; id_src_a = '0; id_src_b = '0;
      mem_dst = '0; wb_dst = '0; mem_wbctl = '0; wb_wbctl = '0;
      @(posedge clk); #(CLK_PERIOD/2);
      // R1: idle inputs select register file everywhere
      check("R1", "idle ex_sel_a", int'(ex_sel_a), 0);
      check("R1", "idle id_sel_b", int'(id_sel_b), 0);
      check("R1", "idle ex_opnd_b", int'(ex_opnd_b), 8'h22);

      for (int sa = 0; sa < 4; sa++)
      for (int sb = 0; sb < 4; sb++)
      for (int md = 0; md < 4; md++)
      for (int wd = 0; wd < 4; wd++)
      for (int mc = 0; mc < 4; mc++)
      for (int wc = 0; wc < 4; wc++) begin
         @(posedge clk);
         ex_src_a = RW'(sa); ex_src_b = RW'(sb);
         id_src_a = RW'(sb); id_src_b = RW'(sa);
         mem_dst = RW'(md); wb_dst = RW'(wd);
         mem_wbctl = 2'(mc); wb_wbctl = 2'(wc);
         id_rf_b = (sa[0]) ? 8'h33 : 8'h44;
         #(CLK_PERIOD/2);
         e = exp_sel(ex_src_a, 1'b0); t = tag_ex(ex_src_a, e);
         check(t, "ex_sel_a", int'(ex_sel_a), e);
         check(t, "ex_opnd_a", int'(ex_opnd_a), exp_val(e, ex_rf_a));
         e = exp_sel(ex_src_b, 1'b0);
         check("R9", "ex_sel_b", int'(ex_sel_b), e);
         check("R9", "ex_opnd_b", int'(ex_opnd_b), exp_val(e, ex_rf_b));
         e = exp_sel(id_src_a, 1'b1);
         t = (mem_wbctl[0] && mem_dst == id_src_a) ? "R7" : "R6";
         check(t, "id_sel_a", int'(id_sel_a), e);
         check(t, "id_opnd_a", int'(id_opnd_a), exp_val(e, id_rf_a));
         e = exp_sel(id_src_b, 1'b1);
         check("R6", "id_sel_b", int'(id_sel_b), e);
         check("R6", "id_opnd_b", int'(id_opnd_b), exp_val(e, id_rf_b));
         check("R8", "id_equal", int'(id_equal),
               int'(exp_val(exp_sel(id_src_a, 1'b1), id_rf_a) ==
                    exp_val(exp_sel(id_src_b, 1'b1), id_rf_b)));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule